// File: doc/BRIEF.md
# Ring Node Packet Bypass

This block is the link-level front end of a node on a unidirectional ring of point-to-point links. On every clock it takes in one 16-bit symbol and a framing flag from the upstream link, and it drives one symbol and flag onto the downstream link. The downstream link never pauses. When there is nothing to send, the block emits an idle symbol.

The first symbol of each packet names the node that should receive it. A packet for this node is taken off the ring and handed to a local receive queue. Any other packet passes through a bypass buffer and leaves on the output, and it can start leaving before its tail has arrived. The local client inserts its own packets one symbol at a time. It may start a packet only while nothing is waiting in the bypass buffer. Traffic that arrives during an insertion is held in the buffer and sent straight after the inserted packet. If the receive queue reports full when a packet for this node arrives, the packet stays on the ring unchanged and a busy counter counts the event.

Top module: `ring_node`

## Requirements
- R1: While reset is asserted, and immediately after it is released, the output link carries an idle symbol, `rxValid` is 0, `busyCount` is 0 and `txReady` is 1.
- R2: Every output symbol that is neither part of a forwarded packet nor part of a local packet is an idle: `outFlag` 0 and `outData` 0.
- R3: A packet starts with the first symbol whose flag is 1 after a flag of 0. Its last symbol is the first symbol with flag 0 after that, so a packet has at least two symbols. Only the first symbol is compared with `myId`. An equal value elsewhere in a packet has no effect.
- R4: A packet whose first symbol differs from `myId` leaves on the output unchanged, symbol for symbol and flag for flag. A symbol sampled at clock edge n appears after edge n+2, even while the rest of the packet is still arriving.
- R5: A packet whose first symbol equals `myId`, with `rxFull` low, is delivered on `rxData` with `rxValid` set for every symbol. A symbol sampled at edge n appears after edge n+1, and `rxLast` is set on the final symbol. None of its symbols reaches the output link.
- R6: `rxFull` is examined in the cycle after the first symbol was sampled. If it is high, the packet is forwarded exactly as in R4 and `busyCount` rises by one after the next edge.
- R7: `txReady` is 1 when the output is idle and the bypass buffer is empty, and it stays 1 through the rest of a local packet. A symbol offered with `txValid` while `txReady` is 1 appears on the output after the next edge. The local packet owns the output until its symbol with flag 0 has been sent.
- R8: Forwarded symbols that arrive during a local packet are buffered in arrival order. They start on the output in the cycle right after the local packet's last symbol, with no idle between.
- R9: While the bypass buffer holds any symbol and no local packet is in progress, `txReady` is 0 and a pending local packet waits.
- R10: Packets may arrive back to back, a first symbol following a last symbol with no idle. Each packet is then still stripped or forwarded by its own first symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| myId | input | 16 | Address of this node |
| inData | input | 16 | Upstream link symbol |
| inFlag | input | 1 | Upstream link framing flag |
| outData | output | 16 | Downstream link symbol |
| outFlag | output | 1 | Downstream link framing flag |
| txValid | input | 1 | Local client offers a symbol |
| txFlag | input | 1 | Framing flag of the offered symbol |
| txData | input | 16 | Offered local symbol |
| txReady | output | 1 | Offered symbol is taken at the next edge |
| rxFull | input | 1 | Local receive queue cannot take a packet |
| rxValid | output | 1 | A stripped symbol is present |
| rxData | output | 16 | Stripped symbol |
| rxLast | output | 1 | Stripped symbol is the last of its packet |
| busyCount | output | 16 | Count of own packets left on the ring for lack of room |

## Verification
Each result has a fixed due cycle:
- A forwarded symbol is due on the output two edges after it is sampled.
- A stripped symbol is due on the receive side one edge after it is sampled.
- The busy count moves one edge after the first symbol reaches the input register.
- An accepted local symbol is due on the output one edge after acceptance.
- `txReady` reflects the state left by the previous edge.

The stimulus table stores each expected value in the row whose check falls in the cycle where that result is due. The bench samples just before it applies the row's inputs, on the falling clock edge, so each comparison sees exactly the registers settled by the preceding rising edge.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;

  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_FWD   = 2'd1,
    OUT_LOCAL = 2'd2
  } outState_t;

  typedef struct packed {
    logic push;     // current input symbol goes into the bypass buffer
    logic strip;    // current input symbol goes to the receive side
    logic busyInc;  // own packet left on the ring, receive queue full
    logic popFwd;   // output register loads the bypass buffer head
    logic sendTx;   // output register loads the local symbol
  } strobes_t;

endpackage

// File: rtl/ring_node_ctrl.sv
module ring_node_ctrl
  import ring_node_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inFlagR,
  input  logic         prevFlagR,
  input  logic [W-1:0] inDataR,
  input  logic [W-1:0] myId,
  input  logic         rxFull,
  input  logic         fifoEmpty,
  input  logic         headFlag,
  input  logic         txValid,
  input  logic         txFlag,
  output strobes_t     strb,
  output logic         txReady
);

  logic      isHead;
  logic      inPkt;
  logic      headMatch;
  logic      takeLocal;
  logic      curStrip;
  logic      stripMode;
  outState_t state;
  outState_t stateNext;

  // Input-side framing and routing decision
  always_comb begin
    isHead    = inFlagR & ~prevFlagR;
    inPkt     = inFlagR | prevFlagR;
    headMatch = isHead & (inDataR == myId);
    takeLocal = headMatch & ~rxFull;
    curStrip  = isHead ? takeLocal : stripMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       stripMode <= 1'b0;
    else if (isHead) stripMode <= takeLocal;
  end

  // Output-side arbitration
  always_comb begin
    txReady      = (state == OUT_LOCAL) | ((state == OUT_IDLE) & fifoEmpty);
    strb.push    = inPkt & ~curStrip;
    strb.strip   = inPkt & curStrip;
    strb.busyInc = headMatch & rxFull;
    strb.popFwd  = ~fifoEmpty & ((state == OUT_IDLE) | (state == OUT_FWD));
    strb.sendTx  = txReady & txValid;
    stateNext    = state;
    unique case (state)
      OUT_IDLE: begin
        if (strb.popFwd && headFlag)     stateNext = OUT_FWD;
        else if (strb.sendTx && txFlag)  stateNext = OUT_LOCAL;
      end
      OUT_FWD: begin
        if (strb.popFwd && !headFlag)    stateNext = OUT_IDLE;
      end
      OUT_LOCAL: begin
        if (strb.sendTx && !txFlag)      stateNext = OUT_IDLE;
      end
      default:                           stateNext = OUT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= OUT_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/ring_node_dp.sv
module ring_node_dp
  import ring_node_pkg::*;
#(
  parameter int W      = 16,
  parameter int DEPTH  = 40,
  parameter int BUSY_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [W-1:0]      inData,
  input  logic              inFlag,
  input  logic [W-1:0]      txData,
  input  logic              txFlag,
  input  strobes_t          strb,
  output logic [W-1:0]      inDataR,
  output logic              inFlagR,
  output logic              prevFlagR,
  output logic              fifoEmpty,
  output logic              headFlag,
  output logic [W-1:0]      outData,
  output logic              outFlag,
  output logic              rxValid,
  output logic [W-1:0]      rxData,
  output logic              rxLast,
  output logic [BUSY_W-1:0] busyCount
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [W:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] count;
  logic [W:0]       head;
  logic             doPush;
  logic             doPop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  // Link input register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inDataR   <= '0;
      inFlagR   <= 1'b0;
      prevFlagR <= 1'b0;
    end else begin
      inDataR   <= inData;
      inFlagR   <= inFlag;
      prevFlagR <= inFlagR;
    end
  end

  // Bypass buffer
  always_comb begin
    head      = mem[rdPtr];
    headFlag  = head[W];
    fifoEmpty = (count == '0);
    doPop     = strb.popFwd & ~fifoEmpty;
    doPush    = strb.push & ((count != FULL_CNT) | doPop);
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {inFlagR, inDataR};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  // Output link register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData <= '0;
      outFlag <= 1'b0;
    end else if (doPop) begin
      outData <= head[W-1:0];
      outFlag <= head[W];
    end else if (strb.sendTx) begin
      outData <= txData;
      outFlag <= txFlag;
    end else begin
      outData <= '0;
      outFlag <= 1'b0;
    end
  end

  // Receive side and busy counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxValid   <= 1'b0;
      rxData    <= '0;
      rxLast    <= 1'b0;
      busyCount <= '0;
    end else begin
      rxValid <= strb.strip;
      rxLast  <= strb.strip & ~inFlagR;
      if (strb.strip)   rxData    <= inDataR;
      if (strb.busyInc) busyCount <= busyCount + 1'b1;
    end
  end

endmodule

// File: rtl/ring_node.sv
module ring_node
  import ring_node_pkg::*;
#(
  parameter int W       = 16,
  parameter int MAX_PKT = 40,
  parameter int BUSY_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [W-1:0]      myId,
  input  logic [W-1:0]      inData,
  input  logic              inFlag,
  output logic [W-1:0]      outData,
  output logic              outFlag,
  input  logic              txValid,
  input  logic              txFlag,
  input  logic [W-1:0]      txData,
  output logic              txReady,
  input  logic              rxFull,
  output logic              rxValid,
  output logic [W-1:0]      rxData,
  output logic              rxLast,
  output logic [BUSY_W-1:0] busyCount
);

  localparam int FIFO_DEPTH = MAX_PKT;

  strobes_t     strb;
  logic [W-1:0] inDataR;
  logic         inFlagR;
  logic         prevFlagR;
  logic         fifoEmpty;
  logic         headFlag;

  ring_node_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inFlagR   (inFlagR),
    .prevFlagR (prevFlagR),
    .inDataR   (inDataR),
    .myId      (myId),
    .rxFull    (rxFull),
    .fifoEmpty (fifoEmpty),
    .headFlag  (headFlag),
    .txValid   (txValid),
    .txFlag    (txFlag),
    .strb      (strb),
    .txReady   (txReady)
  );

  ring_node_dp #(.W(W), .DEPTH(FIFO_DEPTH), .BUSY_W(BUSY_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inData    (inData),
    .inFlag    (inFlag),
    .txData    (txData),
    .txFlag    (txFlag),
    .strb      (strb),
    .inDataR   (inDataR),
    .inFlagR   (inFlagR),
    .prevFlagR (prevFlagR),
    .fifoEmpty (fifoEmpty),
    .headFlag  (headFlag),
    .outData   (outData),
    .outFlag   (outFlag),
    .rxValid   (rxValid),
    .rxData    (rxData),
    .rxLast    (rxLast),
    .busyCount (busyCount)
  );

endmodule

// File: rtl/ring_node_checker.sv
module ring_node_checker #(
  parameter int W      = 16,
  parameter int BUSY_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [W-1:0]      outData,
  input logic              outFlag,
  input logic              txValid,
  input logic              txFlag,
  input logic [W-1:0]      txData,
  input logic              txReady,
  input logic              rxValid,
  input logic              rxLast,
  input logic [BUSY_W-1:0] busyCount
);

  // R2: two flag-0 symbols in a row means an idle, which carries zero data
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!outFlag && !$past(outFlag)) |-> (outData == '0));

  // R5: a stripped packet is delivered without gaps
  a_r5_strip_contiguous: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxLast) |=> rxValid);

  // R5: an end marker only ever comes with a valid symbol
  a_r5_last_valid: assert property (@(posedge clk) disable iff (!rstN)
    rxLast |-> rxValid);

  // R6: the busy counter moves by at most one per cycle
  a_r6_busy_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (busyCount == $past(busyCount)) ||
             (busyCount == BUSY_W'($past(busyCount) + 1'b1)));

  // R7: an accepted local symbol is on the link one cycle later
  a_r7_accept_echo: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (outFlag == $past(txFlag)) && (outData == $past(txData)));

  // R7: a local packet keeps the output until its last symbol
  a_r7_hold_owner: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txFlag) |=> txReady);

endmodule

bind ring_node ring_node_checker #(.W(W), .BUSY_W(BUSY_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .outData   (outData),
  .outFlag   (outFlag),
  .txValid   (txValid),
  .txFlag    (txFlag),
  .txData    (txData),
  .txReady   (txReady),
  .rxValid   (rxValid),
  .rxLast    (rxLast),
  .busyCount (busyCount)
);

// File: tb/test_ring_node.sv
module test_ring_node;

  typedef struct packed {
    logic        iF;
    logic [15:0] iD;
    logic        tV;
    logic        tF;
    logic [15:0] tD;
    logic        full;
    logic        eF;
    logic [15:0] eD;
    logic        eRdy;
    logic        eRv;
    logic [15:0] eRd;
    logic        eRl;
    logic [7:0]  eB;
  } vec_t;

  localparam int NROWS = 34;

  // inputs: iF iD tV tF tD full | expected: eF eD eRdy eRv eRd eRl eB
  localparam vec_t TBL [NROWS] = '{
    '{1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b1,1'b0,16'h0000,1'b0,8'd0}, // 0  R2 idle
    '{1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b1,1'b0,16'h0000,1'b0,8'd0}, // 1
    '{1'b1,16'h0009,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b1,1'b0,16'h0000,1'b0,8'd0}, // 2  R4 pkt to 9
    '{1'b1,16'hA001,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b1,1'b0,16'h0000,1'b0,8'd0}, // 3
    '{1'b0,16'hA002,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0,8'd0}, // 4  R9 buffer busy
    '{1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0, 1'b1,16'h0009,1'b0,1'b0,16'h0000,1'b0,8'd0}, // 5  R4 head out
    '{1'b1,16'h0005,1'b0,1'b0,16'h0000,1'b0, 1'b1,16'hA001,1'b0,1'b0,16'h0000,1'b0,8'd0}, // 6  R5 pkt to 5
    '{1'b1,16'hB001,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'hA002,1'b1,1'b0,16'h0000,1'b0,8'd0}, // 7
    '{1'b0,16'hB002,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b1,1'b1,16'h0005,1'b0,8'd0}, // 8  R5 rx head
    '{1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b1,1'b1,16'hB001,1'b0,8'd0}, // 9
    '{1'b1,16'h0005,1'b0,1'b0,16'h0000,1'b1, 1'b0,16'h0000,1'b1,1'b1,16'hB002,1'b1,8'd0}, // 10 R6 full
    '{1'b1,16'hC001,1'b0,1'b0,16'h0000,1'b1, 1'b0,16'h0000,1'b1,1'b0,16'h0000,1'b0,8'd0}, // 11
    '{1'b0,16'hC002,1'b0,1'b0,16'h0000,1'b1, 1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0,8'd1}, // 12 R6 busy+1
    '{1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0, 1'b1,16'h0005,1'b0,1'b0,16'h0000,1'b0,8'd1}, // 13 R6 forwarded
    '{1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0, 1'b1,16'hC001,1'b0,1'b0,16'h0000,1'b0,8'd1}, // 14
    '{1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'hC002,1'b1,1'b0,16'h0000,1'b0,8'd1}, // 15
    '{1'b1,16'h0003,1'b1,1'b1,16'hD007,1'b0, 1'b0,16'h0000,1'b1,1'b0,16'h0000,1'b0,8'd1}, // 16 R7 insert, R8 traffic
    '{1'b1,16'hE001,1'b1,1'b1,16'hD001,1'b0, 1'b1,16'hD007,1'b1,1'b0,16'h0000,1'b0,8'd1}, // 17
    '{1'b0,16'hE002,1'b1,1'b0,16'hD002,1'b0, 1'b1,16'hD001,1'b1,1'b0,16'h0000,1'b0,8'd1}, // 18
    '{1'b0,16'h0000,1'b1,1'b1,16'hF00A,1'b0, 1'b0,16'hD002,1'b0,1'b0,16'h0000,1'b0,8'd1}, // 19 R9 blocked
    '{1'b0,16'h0000,1'b1,1'b1,16'hF00A,1'b0, 1'b1,16'h0003,1'b0,1'b0,16'h0000,1'b0,8'd1}, // 20 R8 no gap
    '{1'b0,16'h0000,1'b1,1'b1,16'hF00A,1'b0, 1'b1,16'hE001,1'b0,1'b0,16'h0000,1'b0,8'd1}, // 21
    '{1'b0,16'h0000,1'b1,1'b1,16'hF00A,1'b0, 1'b0,16'hE002,1'b1,1'b0,16'h0000,1'b0,8'd1}, // 22 R7 accepted
    '{1'b0,16'h0000,1'b1,1'b0,16'hF001,1'b0, 1'b1,16'hF00A,1'b1,1'b0,16'h0000,1'b0,8'd1}, // 23
    '{1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'hF001,1'b1,1'b0,16'h0000,1'b0,8'd1}, // 24
    '{1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b1,1'b0,16'h0000,1'b0,8'd1}, // 25
    '{1'b1,16'h0005,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b1,1'b0,16'h0000,1'b0,8'd1}, // 26 R10 strip
    '{1'b0,16'h5001,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b1,1'b0,16'h0000,1'b0,8'd1}, // 27
    '{1'b1,16'h0008,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b1,1'b1,16'h0005,1'b0,8'd1}, // 28 R10 then fwd
    '{1'b0,16'h8001,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b1,1'b1,16'h5001,1'b1,8'd1}, // 29
    '{1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0,8'd1}, // 30
    '{1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0, 1'b1,16'h0008,1'b0,1'b0,16'h0000,1'b0,8'd1}, // 31
    '{1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h8001,1'b1,1'b0,16'h0000,1'b0,8'd1}, // 32
    '{1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b1,1'b0,16'h0000,1'b0,8'd1}  // 33
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] myId = 16'h0005;
  logic [15:0] inData = '0;
  logic        inFlag = 1'b0;
  logic        txValid = 1'b0;
  logic        txFlag = 1'b0;
  logic [15:0] txData = '0;
  logic        rxFull = 1'b0;
  logic [15:0] outData;
  logic        outFlag;
  logic        txReady;
  logic        rxValid;
  logic [15:0] rxData;
  logic        rxLast;
  logic [15:0] busyCount;

  int nTests = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  ring_node i_ring_node (
    .clk       (clk),
    .rstN      (rstN),
    .myId      (myId),
    .inData    (inData),
    .inFlag    (inFlag),
    .outData   (outData),
    .outFlag   (outFlag),
    .txValid   (txValid),
    .txFlag    (txFlag),
    .txData    (txData),
    .txReady   (txReady),
    .rxFull    (rxFull),
    .rxValid   (rxValid),
    .rxData    (rxData),
    .rxLast    (rxLast),
    .busyCount (busyCount)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic checkRow(input int k, input vec_t v);
    chk({outFlag, outData} === {v.eF, v.eD},
        $sformatf("row %0d out R2 R4 R6 R7 R8 R10", k), {15'd0, outFlag, outData}, {15'd0, v.eF, v.eD});
    chk(txReady === v.eRdy, $sformatf("row %0d txReady R7 R9", k), 32'(txReady), 32'(v.eRdy));
    chk(rxValid === v.eRv, $sformatf("row %0d rxValid R3 R5 R10", k), 32'(rxValid), 32'(v.eRv));
    if (v.eRv)
      chk({rxLast, rxData} === {v.eRl, v.eRd},
          $sformatf("row %0d rx symbol R5 R10", k), {15'd0, rxLast, rxData}, {15'd0, v.eRl, v.eRd});
    chk(busyCount === 16'(v.eB), $sformatf("row %0d busyCount R6", k), 32'(busyCount), 32'(v.eB));
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nTests++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held during reset
    chk({outFlag, outData} === 17'd0, "R1 out idle in reset", 32'(outData), 32'd0);
    chk(txReady === 1'b1, "R1 txReady in reset", 32'(txReady), 32'd1);
    chk(rxValid === 1'b0, "R1 rxValid in reset", 32'(rxValid), 32'd0);
    chk(busyCount === 16'd0, "R1 busyCount in reset", 32'(busyCount), 32'd0);
    rstN = 1'b1;
    for (int k = 0; k < NROWS; k++) begin
      checkRow(k, TBL[k]);
      inFlag  = TBL[k].iF;
      inData  = TBL[k].iD;
      txValid = TBL[k].tV;
      txFlag  = TBL[k].tF;
      txData  = TBL[k].tD;
      rxFull  = TBL[k].full;
      @(negedge clk);
    end

    // R7: one-cycle echo of a fresh local symbol, then R1: reset mid-packet
    txValid = 1'b1; txFlag = 1'b1; txData = 16'hABCD;
    @(negedge clk);
    chk({outFlag, outData} === {1'b1, 16'hABCD}, "R7 local head out",
        {15'd0, outFlag, outData}, {15'd0, 1'b1, 16'hABCD});
    txValid = 1'b0;
    rstN = 1'b0;
    #1;
    chk({outFlag, outData} === 17'd0, "R1 out idle after reset", {15'd0, outFlag, outData}, 32'd0);
    chk(busyCount === 16'd0, "R1 busyCount cleared", 32'(busyCount), 32'd0);
    chk(txReady === 1'b1, "R1 txReady after reset", 32'(txReady), 32'd1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R2: still idle with no traffic
    chk({outFlag, outData} === 17'd0, "R2 idle after restart", {15'd0, outFlag, outData}, 32'd0);
    finishRun();
  end

endmodule